// File: doc/BRIEF.md
# Decimal Multiplicand Multiples Generator

This block turns a BCD multiplicand of `DIGITS` decimal digits into the five small multiples 1X, 2X, 3X, 4X and 5X. A parallel decimal multiplier selects among these to build its partial products. Every multiple leaves the block as a word of `DIGITS+1` decimal digits in the redundant (4221) code, where each 4-bit digit is worth 4·b3 + 2·b2 + 2·b1 + b0. The extra digit holds the overflow of 3X, 4X and 5X.

Only 3X needs a decimal carry chain. It comes from a digit-serial BCD addition of X and 2X. Doubling X is done another way: each BCD digit is recoded to the (5421) code and the whole vector is moved one bit to the left. 4X doubles 2X again by recoding its (4221) digits to (5211) and moving one bit left. 5X moves the (4221) form of X three bits left, which gives (5211) digits, and a single full adder per digit converts them back to (4221). All five results are captured in one output register stage. A synchronous active-high reset clears them to zero.

Top module: `dmul_multiples`

## Requirements
- R1: While `rst` is high at a rising clock edge, all five outputs are zero after that edge.
- R2: Each output reflects the `x_bcd` value sampled at the previous rising edge, and stays unchanged while `x_bcd` is held.
- R3: `m1_o` is X with each BCD digit (b3,b2,b1,b0) coded as (b3|b2, b3, b3|b1, b0) and a zero top digit.
- R4: `m2_o` decodes (digit weights 4,2,2,1 and digit i worth 10^i) to exactly 2·X.
- R5: `m3_o` decodes to exactly 3·X.
- R6: `m4_o` decodes to exactly 4·X.
- R7: `m5_o` decodes to exactly 5·X, so its lowest digit is always worth 0 or 5.
- R8: Every digit of `m2_o` and `m3_o` uses the same per-digit coding as R3, applied to the BCD digits of 2X and 3X.
- R9: With every input digit at 9, all multiples are still represented in full within `DIGITS+1` digits, and the top digit of `m1_o` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| x_bcd | input | 4*DIGITS | Multiplicand, BCD, digit 0 in bits 3:0 |
| m1_o | output | 4*(DIGITS+1) | 1X in (4221) |
| m2_o | output | 4*(DIGITS+1) | 2X in (4221) |
| m3_o | output | 4*(DIGITS+1) | 3X in (4221) |
| m4_o | output | 4*(DIGITS+1) | 4X in (4221) |
| m5_o | output | 4*(DIGITS+1) | 5X in (4221) |

## Verification
The datapath holds no state besides the output register. Any internal fault therefore shows up one clock after the offending input, as a multiple whose weighted digit sum differs from k·X. A lost cross-digit bit in a shift usually disturbs only one digit position, so the inputs include all-nines, alternating 5/0 patterns and values with many digits at 5 or above. These inputs push a bit across every digit boundary. A recoder that picks a legal but non-canonical (4221) form would still decode to the right value. For that reason the exact bit patterns of 1X, 2X and 3X are compared as well.

// File: rtl/dmul_pkg.sv
package dmul_pkg;

  typedef logic [3:0] dig_t;

  // BCD digit -> (4221), canonical form
  function automatic dig_t bcd_to_c4221(input dig_t b);
    return {b[3] | b[2], b[3], b[3] | b[1], b[0]};
  endfunction

  // BCD digit -> (5421), unique mapping
  function automatic dig_t bcd_to_c5421(input dig_t b);
    return (b > 4'd4) ? {1'b1, 3'(b - 4'd5)} : b;
  endfunction

  // Weighted value of a (4221) digit
  function automatic logic [3:0] val_c4221(input dig_t c);
    return 4'({c[3], 2'b00}) + 4'({c[2], 1'b0}) + 4'({c[1], 1'b0}) + 4'(c[0]);
  endfunction

  // Value 0..9 -> non-redundant (5211) subset
  function automatic dig_t val_to_c5211(input logic [3:0] v);
    dig_t r;
    case (v)
      4'd0: r = 4'b0000;
      4'd1: r = 4'b0001;
      4'd2: r = 4'b0100;
      4'd3: r = 4'b0101;
      4'd4: r = 4'b0111;
      4'd5: r = 4'b1000;
      4'd6: r = 4'b1001;
      4'd7: r = 4'b1100;
      4'd8: r = 4'b1101;
      default: r = 4'b1111;
    endcase
    return r;
  endfunction

  function automatic dig_t c4221_to_c5211(input dig_t c);
    return val_to_c5211(val_c4221(c));
  endfunction

  // (5211) -> (4221) with one full adder over the three odd-weight bits:
  // 5z3+2z2+z1+z0 = 4z3 + 2z2 + (z3+z1+z0) = 4z3 + 2z2 + 2cy + sm
  function automatic dig_t c5211_to_c4221(input dig_t z);
    logic sm, cy;
    sm = z[3] ^ z[1] ^ z[0];
    cy = (z[3] & z[1]) | (z[3] & z[0]) | (z[1] & z[0]);
    return {z[3], z[2], cy, sm};
  endfunction

endpackage

// File: rtl/dmul_x2_bcd.sv
// Doubles a BCD word without carry propagation: (5421) recode + 1-bit shift.
module dmul_x2_bcd
  import dmul_pkg::*;
#(
  parameter int DIGITS = 8
) (
  input  logic [4*DIGITS-1:0] x_bcd,
  output logic [4*DIGITS-1:0] dbl_bcd,
  output logic                dbl_top
);
  localparam int W = 4 * DIGITS;

  logic [W-1:0] v5421;

  for (genvar i = 0; i < DIGITS; i++) begin : g_rec
    assign v5421[4*i +: 4] = bcd_to_c5421(x_bcd[4*i +: 4]);
  end

  // The weight-5 bit of each digit lands as the weight-1 bit one digit up.
  assign dbl_bcd = {v5421[W-2:0], 1'b0};
  assign dbl_top = v5421[W-1];
endmodule

// File: rtl/dmul_x2_4221.sv
// Doubles a (4221) word without carry propagation: (5211) recode + 1-bit shift.
module dmul_x2_4221
  import dmul_pkg::*;
#(
  parameter int DIGITS = 8
) (
  input  logic [4*DIGITS-1:0] in_4221,
  output logic [4*DIGITS-1:0] dbl_4221,
  output logic                dbl_top
);
  localparam int W = 4 * DIGITS;

  logic [W-1:0] v5211;

  for (genvar i = 0; i < DIGITS; i++) begin : g_rec
    assign v5211[4*i +: 4] = c4221_to_c5211(in_4221[4*i +: 4]);
  end

  assign dbl_4221 = {v5211[W-2:0], 1'b0};
  assign dbl_top  = v5211[W-1];
endmodule

// File: rtl/dmul_x5.sv
// Quintuples a (4221) word: 3-bit shift gives (5211) digits, then recode.
module dmul_x5
  import dmul_pkg::*;
#(
  parameter int DIGITS = 8
) (
  input  logic [4*DIGITS-1:0]     x_4221,
  output logic [4*(DIGITS+1)-1:0] q_4221
);
  localparam int OD = DIGITS + 1;

  logic [4*OD-1:0] v5211;

  assign v5211 = {1'b0, x_4221, 3'b000};

  for (genvar i = 0; i < OD; i++) begin : g_rec
    assign q_4221[4*i +: 4] = c5211_to_c4221(v5211[4*i +: 4]);
  end
endmodule

// File: rtl/dmul_bcd_add.sv
// Ripple BCD adder, one digit cell per position.
module dmul_bcd_add #(
  parameter int DIGITS = 8
) (
  input  logic [4*DIGITS-1:0] a_bcd,
  input  logic [4*DIGITS-1:0] b_bcd,
  output logic [4*DIGITS-1:0] s_bcd,
  output logic                cout
);
  logic [DIGITS:0] cy;

  assign cy[0] = 1'b0;

  for (genvar i = 0; i < DIGITS; i++) begin : g_cell
    logic [4:0] raw;
    logic [3:0] fix;
    logic       over;
    assign raw  = {1'b0, a_bcd[4*i +: 4]} + {1'b0, b_bcd[4*i +: 4]} + {4'b0000, cy[i]};
    assign over = (raw > 5'd9);
    assign fix  = raw[3:0] + 4'd6;
    assign s_bcd[4*i +: 4] = over ? fix : raw[3:0];
    assign cy[i+1] = over;
  end

  assign cout = cy[DIGITS];
endmodule

// File: rtl/dmul_multiples.sv
module dmul_multiples
  import dmul_pkg::*;
#(
  parameter int DIGITS = 8
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [4*DIGITS-1:0]     x_bcd,
  output logic [4*(DIGITS+1)-1:0] m1_o,
  output logic [4*(DIGITS+1)-1:0] m2_o,
  output logic [4*(DIGITS+1)-1:0] m3_o,
  output logic [4*(DIGITS+1)-1:0] m4_o,
  output logic [4*(DIGITS+1)-1:0] m5_o
);
  localparam int XW = 4 * DIGITS;
  localparam int OD = DIGITS + 1;
  localparam int MW = 4 * OD;

  // 1X
  logic [XW-1:0] x_4221;
  for (genvar i = 0; i < DIGITS; i++) begin : g_x1
    assign x_4221[4*i +: 4] = bcd_to_c4221(x_bcd[4*i +: 4]);
  end
  logic [MW-1:0] m1_n;
  assign m1_n = {4'b0000, x_4221};

  // 2X
  logic [XW-1:0] dbl_bcd;
  logic          dbl_top;
  dmul_x2_bcd #(.DIGITS(DIGITS)) u_x2 (
    .x_bcd  (x_bcd),
    .dbl_bcd(dbl_bcd),
    .dbl_top(dbl_top)
  );
  logic [MW-1:0] m2_bcd, m2_n;
  assign m2_bcd = {3'b000, dbl_top, dbl_bcd};
  for (genvar i = 0; i < OD; i++) begin : g_x2
    assign m2_n[4*i +: 4] = bcd_to_c4221(m2_bcd[4*i +: 4]);
  end

  // 4X: double the low digits of 2X; the top 2X digit (0 or 1) doubles
  // into the weight-2 bit of the top digit.
  logic [XW-1:0] q_lo;
  logic          q_cy;
  dmul_x2_4221 #(.DIGITS(DIGITS)) u_x4 (
    .in_4221 (m2_n[XW-1:0]),
    .dbl_4221(q_lo),
    .dbl_top (q_cy)
  );
  logic [MW-1:0] m4_n;
  assign m4_n = {2'b00, m2_n[XW], q_cy, q_lo};

  // 3X = X + 2X, the only carry chain
  logic [XW-1:0] s3;
  logic          c3;
  dmul_bcd_add #(.DIGITS(DIGITS)) u_add (
    .a_bcd(x_bcd),
    .b_bcd(dbl_bcd),
    .s_bcd(s3),
    .cout (c3)
  );
  logic [MW-1:0] m3_bcd, m3_n;
  assign m3_bcd = {2'b00, dbl_top & c3, dbl_top ^ c3, s3};
  for (genvar i = 0; i < OD; i++) begin : g_x3
    assign m3_n[4*i +: 4] = bcd_to_c4221(m3_bcd[4*i +: 4]);
  end

  // 5X
  logic [MW-1:0] m5_n;
  dmul_x5 #(.DIGITS(DIGITS)) u_x5 (
    .x_4221(x_4221),
    .q_4221(m5_n)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      m1_o <= '0;
      m2_o <= '0;
      m3_o <= '0;
      m4_o <= '0;
      m5_o <= '0;
    end else begin
      m1_o <= m1_n;
      m2_o <= m2_n;
      m3_o <= m3_n;
      m4_o <= m4_n;
      m5_o <= m5_n;
    end
  end
endmodule

// File: rtl/dmul_multiples_chk.sv
module dmul_multiples_chk #(
  parameter int DIGITS = 8
) (
  input logic                    clk,
  input logic                    rst,
  input logic [4*DIGITS-1:0]     x_bcd,
  input logic [4*(DIGITS+1)-1:0] m1_o,
  input logic [4*(DIGITS+1)-1:0] m2_o,
  input logic [4*(DIGITS+1)-1:0] m3_o,
  input logic [4*(DIGITS+1)-1:0] m4_o,
  input logic [4*(DIGITS+1)-1:0] m5_o
);
  localparam int MW = 4 * (DIGITS + 1);

  function automatic logic canon(input logic [MW-1:0] w);
    logic ok;
    ok = 1'b1;
    for (int i = 0; i < DIGITS + 1; i++) begin
      if (w[4*i+2] && !(w[4*i+3] && w[4*i+1])) ok = 1'b0;
    end
    return ok;
  endfunction

  logic [3:0] m5_low_val;
  assign m5_low_val = 4'({m5_o[3], 2'b00}) + 4'({m5_o[2], 1'b0}) +
                      4'({m5_o[1], 1'b0}) + 4'(m5_o[0]);

  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (m1_o == '0 && m2_o == '0 && m3_o == '0 && m4_o == '0 && m5_o == '0));

  assert_hold_R2: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $stable(x_bcd)) |=>
      ($stable(m1_o) && $stable(m2_o) && $stable(m3_o) && $stable(m4_o) && $stable(m5_o)));

  assert_double_even_R4: assert property (@(posedge clk) disable iff (rst)
    m2_o[0] == 1'b0);

  assert_five_low_R7: assert property (@(posedge clk) disable iff (rst)
    (m5_low_val == 4'd0) || (m5_low_val == 4'd5));

  assert_canon_R8: assert property (@(posedge clk) disable iff (rst)
    canon(m2_o) && canon(m3_o) && canon(m1_o));

  assert_top_zero_R9: assert property (@(posedge clk) disable iff (rst)
    m1_o[MW-1 -: 4] == 4'b0000);
endmodule

bind dmul_multiples dmul_multiples_chk #(.DIGITS(DIGITS)) u_chk (
  .clk  (clk),
  .rst  (rst),
  .x_bcd(x_bcd),
  .m1_o (m1_o),
  .m2_o (m2_o),
  .m3_o (m3_o),
  .m4_o (m4_o),
  .m5_o (m5_o)
);

// File: tb/test_dmul_multiples.sv
`timescale 1ns/1ps
module test_dmul_multiples;
  localparam int D  = 8;
  localparam int XW = 4 * D;
  localparam int MW = 4 * (D + 1);
  localparam int NV = 8;
  localparam longint unsigned VECS [NV] = '{
    64'd0, 64'd1, 64'd12345678, 64'd99999999,
    64'd50505050, 64'd4999999, 64'd87654321, 64'd19283746
  };

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [XW-1:0] x_bcd = '0;
  logic [MW-1:0] m1_o, m2_o, m3_o, m4_o, m5_o;
  int            n_run = 0;
  int            n_fail = 0;
  bit            done = 1'b0;

  always #4 clk = ~clk;

  dmul_multiples #(.DIGITS(D)) i_dmul_multiples (
    .clk(clk), .rst(rst), .x_bcd(x_bcd),
    .m1_o(m1_o), .m2_o(m2_o), .m3_o(m3_o), .m4_o(m4_o), .m5_o(m5_o)
  );

  function automatic logic [XW-1:0] enc_bcd(input longint unsigned v);
    logic [XW-1:0] r;
    longint unsigned t;
    t = v;
    for (int i = 0; i < D; i++) begin
      r[4*i +: 4] = 4'(t % 10);
      t = t / 10;
    end
    return r;
  endfunction

  function automatic logic [MW-1:0] enc_4221(input longint unsigned v);
    logic [MW-1:0] r;
    logic [3:0] b;
    longint unsigned t;
    t = v;
    for (int i = 0; i < D + 1; i++) begin
      b = 4'(t % 10);
      t = t / 10;
      r[4*i +: 4] = {b[3] | b[2], b[3], b[3] | b[1], b[0]};
    end
    return r;
  endfunction

  function automatic longint unsigned dec_4221(input logic [MW-1:0] w);
    longint unsigned r;
    r = 0;
    for (int i = D; i >= 0; i--) begin
      r = r * 10 + 4 * w[4*i+3] + 2 * w[4*i+2] + 2 * w[4*i+1] + w[4*i];
    end
    return r;
  endfunction

  task automatic check(input bit ok, input string tag, input longint unsigned got,
                       input longint unsigned exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", tag, got, got, exp, exp);
    end
  endtask

  task automatic apply(input longint unsigned v);
    @(negedge clk);
    x_bcd = enc_bcd(v);
    @(negedge clk);
  endtask

  task automatic check_all(input longint unsigned v);
    check(m1_o == enc_4221(v), "R3 m1 coding", m1_o, enc_4221(v));
    check(dec_4221(m2_o) == 2 * v, "R4 2X value", dec_4221(m2_o), 2 * v);
    check(dec_4221(m3_o) == 3 * v, "R5 3X value", dec_4221(m3_o), 3 * v);
    check(dec_4221(m4_o) == 4 * v, "R6 4X value", dec_4221(m4_o), 4 * v);
    check(dec_4221(m5_o) == 5 * v, "R7 5X value", dec_4221(m5_o), 5 * v);
    check(m2_o == enc_4221(2 * v), "R8 2X coding", m2_o, enc_4221(2 * v));
    check(m3_o == enc_4221(3 * v), "R8 3X coding", m3_o, enc_4221(3 * v));
  endtask

  task automatic check_zero(input string tag);
    check(m1_o == '0 && m2_o == '0 && m3_o == '0 && m4_o == '0 && m5_o == '0,
          tag, dec_4221(m1_o) + dec_4221(m2_o) + dec_4221(m3_o) + dec_4221(m4_o)
          + dec_4221(m5_o), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    // R1: reset state with a nonzero input present
    x_bcd = enc_bcd(64'd12345678);
    repeat (3) @(negedge clk);
    check_zero("R1 reset state");
    rst = 1'b0;

    // Table walk
    for (int k = 0; k < NV; k++) begin
      apply(VECS[k]);
      check_all(VECS[k]);
    end

    // R2: new input does not show before the next edge, shows after it
    apply(64'd24681357);
    @(negedge clk);
    x_bcd = enc_bcd(64'd97531864);
    #1;
    check(dec_4221(m5_o) == 5 * 64'd24681357, "R2 old value held before edge",
          dec_4221(m5_o), 5 * 64'd24681357);
    @(negedge clk);
    check(dec_4221(m3_o) == 3 * 64'd97531864, "R2 new value after one edge",
          dec_4221(m3_o), 3 * 64'd97531864);
    @(negedge clk);
    check(dec_4221(m4_o) == 4 * 64'd97531864, "R2 held input keeps output",
          dec_4221(m4_o), 4 * 64'd97531864);

    // R9: all nines, full width
    apply(64'd99999999);
    check(m1_o[MW-1 -: 4] == 4'b0000, "R9 m1 top digit zero", m1_o[MW-1 -: 4], 0);
    check(dec_4221(m5_o) == 64'd499999995, "R9 5X all nines", dec_4221(m5_o),
          64'd499999995);
    check(dec_4221(m4_o) == 64'd399999996, "R9 4X all nines", dec_4221(m4_o),
          64'd399999996);
    check(dec_4221(m3_o) == 64'd299999997, "R9 3X all nines", dec_4221(m3_o),
          64'd299999997);

    // Carries across every boundary for 2X/4X/5X
    apply(64'd55555555);
    check_all(64'd55555555);

    // R1: synchronous reset mid-run
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check_zero("R1 reset mid-run");
    rst = 1'b0;
    apply(64'd31415926);
    check_all(64'd31415926);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule